// File: doc/BRIEF.md
# I2S Audio Transmit Controller

This block is a register-programmed serial audio transmitter. Software writes 32-bit samples over a small single-cycle register bus into a transmit queue. It then enables the transfer, and the block streams the samples out MSB-first in standard I2S framing: a word-select line that is low for the left channel and high for the right channel, a bit clock, and a serial data line. A master clock and the bit clock come from the block clock through two programmable dividers that are cascaded. Software can read the queue fill level at any time to keep the queue topped up while audio is playing.

The sample width is a runtime field, so 16-bit and 24-bit audio use the same hardware. Queue words are assigned to slots in order, starting with the left channel after each start. When the queue runs dry, the serializer sends silent slots of the same length, so the frame does not slip. After a transfer is stopped, a write to the clear offset empties the queue and returns the serializer to its idle state.

Top module: `i2s_tx_top`

## Requirements
- R1: After reset, offset 0x00 reads 0x0000000F, and offsets 0x08, 0x1C and 0x0C read 0. The bit clock is low, word select is high and serial data is low.
- R2: Read data appears on the cycle after the read strobe. Offset 0x00 holds the width field in bits [4:0]. Offset 0x08 holds the master divider in [23:16], a stored receive divider in [15:8] and the transmit bit-clock divider in [7:0]. Offset 0x1C holds transmit enable in bit 0 and a stored receive enable in bit 1. Unimplemented bits read 0, unmapped offsets (e.g. 0x04, 0x10, 0x28) read 0, and the receive fields have no effect on the outputs.
- R3: Each write to offset 0x24 pushes one word. Bits [5:0] of offset 0x0C read the queue occupancy, which never exceeds 32.
- R4: A write to offset 0x24 while 32 words are queued is dropped: the level stays at 32 and the word is never transmitted.
- R5: With master divider M, the master clock output toggles every M+1 clock cycles.
- R6: While bit 0 of 0x1C is set, with bit-clock divider B, the bit clock toggles every (M+1)(B+1) clock cycles.
- R7: With width field F, each slot carries W=F+1 bits, taken from bits [W-1:0] of the queue word and sent MSB first. Higher word bits are ignored.
- R8: Data and word select change on bit-clock falling edges. Word select toggles together with the last bit of a slot, which is one bit clock before the next slot's MSB. It is low for left and high for right, and queue words fill slots in order starting with left after each start.
- R9: When a slot starts with the queue empty, the slot is all zeros and keeps its full W-bit length.
- R10: A write to offset 0x20 empties the queue (level 0, old words never sent), forces the bit clock low, word select high and data low, and restarts framing so that the next start again begins on the left channel.
- R11: Clearing bit 0 of 0x1C freezes the bit clock, word select and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and audio source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered |
| mclk_o | output | 1 | Divided master clock |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, low for left |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
A register read returns on the cycle after its strobe. A write takes effect at the edge that samples it, so a level read issued right after a push already sees the new count. The serial outputs are registered and change at the same edge that drops the bit clock. The bench therefore decodes them at bit-clock rising edges, in the way a receiver would, and compares each completed slot against a queue of the words it accepted, tracking slot length, channel and content. Divider intervals are measured on every clock, and the first two toggles after any divider change or start are skipped because they cover a partial interval.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  // byte offsets seen by software
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_CKDIV  = 'h08;
  localparam int OFS_LEVEL  = 'h0C;
  localparam int OFS_XFER   = 'h1C;
  localparam int OFS_CLEAR  = 'h20;
  localparam int OFS_TXDATA = 'h24;

  // transfer control bit positions
  localparam int XFER_TX_BIT = 0;
  localparam int XFER_RX_BIT = 1;
endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
  import i2s_tx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DW = 32,
  parameter int DIV_W = 8,
  parameter int WSEL_W = 5,
  parameter int LVL_W = 6,
  parameter logic [WSEL_W-1:0] WSEL_RST = WSEL_W'(15)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [LVL_W-1:0]  level,
  output logic [WSEL_W-1:0] wsel,
  output logic [DIV_W-1:0]  mdiv,
  output logic [DIV_W-1:0]  bdiv,
  output logic              tx_en,
  output logic              push,
  output logic              clr
);
  localparam int CKW = 3 * DIV_W;

  logic [WSEL_W-1:0] wsel_q;
  logic [CKW-1:0]    ckdiv_q;
  logic [1:0]        xfer_q;
  logic [DW-1:0]     rd_mux;

  logic hit_ctrl, hit_ckdiv, hit_level, hit_xfer, hit_clear, hit_data;
  assign hit_ctrl  = bus_addr == ADDR_W'(OFS_CTRL);
  assign hit_ckdiv = bus_addr == ADDR_W'(OFS_CKDIV);
  assign hit_level = bus_addr == ADDR_W'(OFS_LEVEL);
  assign hit_xfer  = bus_addr == ADDR_W'(OFS_XFER);
  assign hit_clear = bus_addr == ADDR_W'(OFS_CLEAR);
  assign hit_data  = bus_addr == ADDR_W'(OFS_TXDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel_q  <= WSEL_RST;
      ckdiv_q <= '0;
      xfer_q  <= '0;
    end else if (bus_wr) begin
      if (hit_ctrl)  wsel_q  <= bus_wdata[WSEL_W-1:0];
      if (hit_ckdiv) ckdiv_q <= bus_wdata[CKW-1:0];
      if (hit_xfer)  xfer_q  <= bus_wdata[1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)  rd_mux[WSEL_W-1:0] = wsel_q;
    if (hit_ckdiv) rd_mux[CKW-1:0]    = ckdiv_q;
    if (hit_xfer)  rd_mux[1:0]        = xfer_q;
    if (hit_level) rd_mux[LVL_W-1:0]  = level;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign wsel  = wsel_q;
  assign mdiv  = ckdiv_q[3*DIV_W-1:2*DIV_W];
  assign bdiv  = ckdiv_q[DIV_W-1:0];
  assign tx_en = xfer_q[XFER_TX_BIT];
  assign push  = bus_wr && hit_data;
  assign clr   = bus_wr && hit_clear;
endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW = 32,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    rd_data,
  output logic             avail,
  output logic [LVL_W-1:0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;
  logic             full, wr_ok;

  assign full  = cnt == LVL_W'(DEPTH);
  assign wr_ok = push && !full;

  // storage without reset, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      avail <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (pop)   rp <= rp + AW'(1);
      if (wr_ok && !pop)      cnt <= cnt + LVL_W'(1);
      else if (pop && !wr_ok) cnt <= cnt - LVL_W'(1);
      // lags one cycle so the registered read word is valid before use
      avail <= cnt != '0;
    end
  end

  assign level = cnt;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (cnt == $past(cnt)));

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tx_en,
  input  logic [DIV_W-1:0] mdiv,
  input  logic [DIV_W-1:0] bdiv,
  output logic             mclk,
  output logic             bclk,
  output logic             bclk_fall
);
  logic [DIV_W-1:0] mcnt, bcnt;
  logic             mtick, bwrap;

  assign mtick = mcnt >= mdiv;
  assign bwrap = bcnt >= bdiv;
  assign bclk_fall = mtick && tx_en && bwrap && bclk && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt <= '0;
      mclk <= 1'b0;
    end else if (mtick) begin
      mcnt <= '0;
      mclk <= ~mclk;
    end else begin
      mcnt <= mcnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bcnt <= '0;
      bclk <= 1'b0;
    end else if (mtick && tx_en) begin
      if (bwrap) begin
        bcnt <= '0;
        bclk <= ~bclk;
      end else begin
        bcnt <= bcnt + DIV_W'(1);
      end
    end
  end

  // R11
  bclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !clr) |=> $stable(bclk));
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          fall,
  input  logic [SW-1:0] wsel,
  input  logic          avail,
  input  logic [DW-1:0] word,
  output logic          pop,
  output logic          ws,
  output logic          sd
);
  logic [DW-1:0] sh;
  logic [SW-1:0] cnt;
  logic          primed;
  logic          slot_end;
  logic [SW-1:0] align;

  // first falling edge after a start closes a virtual slot
  assign slot_end = !primed || (cnt == wsel);
  assign pop      = fall && slot_end && avail;
  assign align    = SW'(DW - 1) - wsel;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh     <= '0;
      cnt    <= '0;
      primed <= 1'b0;
      ws     <= 1'b1;
      sd     <= 1'b0;
    end else if (fall) begin
      sd     <= sh[DW-1];
      primed <= 1'b1;
      if (slot_end) begin
        cnt <= '0;
        ws  <= ~ws;
        sh  <= avail ? (word << align) : '0;
      end else begin
        cnt <= cnt + SW'(1);
        sh  <= sh << 1;
      end
    end
  end

  // R8
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall && !clr) |=> $stable(ws));

  // R10
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ws && !sd));
endmodule

// File: rtl/i2s_tx_top.sv
module i2s_tx_top #(
  parameter int ADDR_W = 6,
  parameter int DW = 32,
  parameter int DEPTH = 32,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              ws_o,
  output logic              sd_o
);
  localparam int LVL_W  = $clog2(DEPTH) + 1;
  localparam int WSEL_W = $clog2(DW);

  logic [WSEL_W-1:0] wsel;
  logic [DIV_W-1:0]  mdiv, bdiv;
  logic              tx_en, push, clr, pop, avail, fall;
  logic [LVL_W-1:0]  level;
  logic [DW-1:0]     head;

  i2s_tx_regs #(
    .ADDR_W(ADDR_W), .DW(DW), .DIV_W(DIV_W), .WSEL_W(WSEL_W), .LVL_W(LVL_W),
    .WSEL_RST(WSEL_W'(15))
  ) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level(level), .wsel(wsel),
    .mdiv(mdiv), .bdiv(bdiv), .tx_en(tx_en), .push(push), .clr(clr)
  );

  i2s_tx_fifo #(.DEPTH(DEPTH), .DW(DW), .LVL_W(LVL_W)) fifo_i (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .push_data(bus_wdata),
    .pop(pop), .rd_data(head), .avail(avail), .level(level)
  );

  i2s_tx_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst(rst), .clr(clr), .tx_en(tx_en), .mdiv(mdiv), .bdiv(bdiv),
    .mclk(mclk_o), .bclk(bclk_o), .bclk_fall(fall)
  );

  i2s_tx_shifter #(.DW(DW), .SW(WSEL_W)) shifter_i (
    .clk(clk), .rst(rst), .clr(clr), .fall(fall), .wsel(wsel), .avail(avail),
    .word(head), .pop(pop), .ws(ws_o), .sd(sd_o)
  );

  // R3
  rd_level_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(i2s_tx_pkg::OFS_LEVEL)) |=>
      (bus_rdata[LVL_W-1:0] == $past(level) && bus_rdata[DW-1:LVL_W] == '0));

  // R3
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (level == LVL_W'(DEPTH) && push && !pop && !clr) |=> (level == LVL_W'(DEPTH)));
endmodule

// File: tb/i2s_tx_top_tb.sv
module i2s_tx_top_tb_top;
  import i2s_tx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mclk_o, bclk_o, ws_o, sd_o;

  i2s_tx_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mclk_o(mclk_o),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model state
  int exp_m = 0, exp_b = 0;
  int m_arm = 0, m_cnt = 0, b_arm = 0, b_cnt = 0;
  int edges = 0;
  int width = 16;
  int k_words = 0, zeros = 0;
  bit run_mon = 0, dec_on = 0, dec_first = 0, dec_have = 0;
  logic mclk_p = 1'b0, bclk_p = 1'b0, ws_last = 1'b1;
  logic [31:0] acc = '0;
  int nbits = 0;
  logic [31:0] expq[$];

  task automatic finish_word(input logic ch);
    logic [31:0] e;
    if (expq.size() > 0) begin
      e = expq.pop_front();
      check(acc == e, "R7 slot data", acc, e);
      check(nbits == width, "R7 slot length", nbits, width);
      check(ch == 1'(k_words % 2), "R8 channel order", ch, k_words % 2);
      k_words++;
    end else begin
      check(acc == 0 && nbits == width, "R9 silent slot", acc, 0);
      zeros++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      m_cnt++;
      if (mclk_o !== mclk_p) begin
        if (m_arm >= 2) check(m_cnt == exp_m + 1, "R5 mclk half period", m_cnt, exp_m + 1);
        m_arm++;
        m_cnt = 0;
      end
      mclk_p = mclk_o;
      b_cnt++;
      if (bclk_o !== bclk_p) begin
        edges++;
        if (run_mon && b_arm >= 2)
          check(b_cnt == (exp_m + 1) * (exp_b + 1), "R6 bclk half period", b_cnt,
                (exp_m + 1) * (exp_b + 1));
        b_arm++;
        b_cnt = 0;
        if (bclk_o && dec_on) begin
          acc = {acc[30:0], sd_o};
          nbits++;
          if (!dec_have) begin
            dec_have = 1;
            ws_last = ws_o;
          end else if (ws_o !== ws_last) begin
            if (dec_first) dec_first = 0;
            else finish_word(ws_last);
            acc = '0;
            nbits = 0;
            ws_last = ws_o;
          end
        end
      end
      bclk_p = bclk_o;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_wdata = d;
    bus_wr = 1'b1;
    if (a == OFS_CKDIV) begin
      exp_m = int'(d[23:16]);
      exp_b = int'(d[7:0]);
      m_arm = 0;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic start_tx();
    dec_on = 1; dec_first = 1; dec_have = 0;
    acc = '0; nbits = 0; k_words = 0; zeros = 0;
    b_arm = 0; run_mon = 1;
    wr(OFS_XFER, 32'h3);
  endtask

  task automatic stop_and_clear(input int tag_only);
    int e0;
    logic w0, s0;
    run_mon = 0;
    wr(OFS_XFER, 32'h0);
    repeat (2) @(negedge clk);
    e0 = edges; w0 = ws_o; s0 = sd_o;
    repeat (60) @(negedge clk);
    check(edges == e0, "R11 bclk frozen", edges, e0);
    check(ws_o == w0 && sd_o == s0, "R11 ws/sd frozen", {ws_o, sd_o}, {w0, s0});
    dec_on = 0;
    wr(OFS_CLEAR, 32'h0);
    check(bclk_o == 1'b0 && ws_o == 1'b1 && sd_o == 1'b0, "R10 idle after clear",
          {bclk_o, ws_o, sd_o}, 3'b010);
    if (tag_only != 0) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w;
    int e0, pushed;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(bclk_o == 1'b0 && ws_o == 1'b1 && sd_o == 1'b0, "R1 idle pins",
          {bclk_o, ws_o, sd_o}, 3'b010);
    rd(OFS_CTRL, r);  check(r == 32'h0000000F, "R1 width reset", r, 32'hF);
    rd(OFS_CKDIV, r); check(r == 0, "R1 divider reset", r, 0);
    rd(OFS_XFER, r);  check(r == 0, "R1 xfer reset", r, 0);
    rd(OFS_LEVEL, r); check(r == 0, "R1 level reset", r, 0);

    // R2 register fields and unmapped offsets
    wr(OFS_CTRL, 32'hFFFF_FFF7);
    rd(OFS_CTRL, r);  check(r == 32'h17, "R2 width field", r, 32'h17);
    wr(OFS_CKDIV, 32'hAB12_3456);
    rd(OFS_CKDIV, r); check(r == 32'h0012_3456, "R2 divider fields", r, 32'h0012_3456);
    rd('h04, r); check(r == 0, "R2 unmapped 0x04", r, 0);
    rd('h10, r); check(r == 0, "R2 unmapped 0x10", r, 0);
    rd('h28, r); check(r == 0, "R2 unmapped 0x28", r, 0);
    e0 = edges;
    wr(OFS_XFER, 32'hFFFF_FFFE);
    rd(OFS_XFER, r); check(r == 32'h2, "R2 receive stub bit", r, 2);
    repeat (30) @(negedge clk);
    check(edges == e0, "R2 receive enable no effect", edges, e0);
    wr(OFS_XFER, 32'h0);

    // R5 master clock
    wr(OFS_CKDIV, 32'h0002_0001);
    repeat (40) @(negedge clk);

    // 16-bit stream with underflow tail
    wr(OFS_CTRL, 32'd15);
    width = 16;
    wr(OFS_CKDIV, 32'h0001_5501);
    for (int i = 0; i < 6; i++) begin
      w = 32'hBEEF_0000 | (32'h8A01 + 32'(i) * 32'h0713);
      wr(OFS_TXDATA, w);
      expq.push_back(w & 32'h0000_FFFF);
    end
    rd(OFS_LEVEL, r); check(r == 6, "R3 level after pushes", r, 6);
    start_tx();
    rd(OFS_XFER, r); check(r == 32'h3, "R2 xfer readback", r, 3);
    while (!(expq.size() == 0 && zeros >= 2)) @(negedge clk);
    check(k_words == 6, "R8 words delivered", k_words, 6);
    rd(OFS_LEVEL, r); check(r == 0, "R3 level drained", r, 0);
    stop_and_clear(0);

    // 24-bit stream, full queue, dropped write, streaming refill
    wr(OFS_CTRL, 32'd23);
    width = 24;
    wr(OFS_CKDIV, 32'h0000_0002);
    for (int i = 0; i < 32; i++) begin
      w = 32'hC000_0000 + 32'(i) * 32'h0103_0507 + 32'h0080_4001;
      wr(OFS_TXDATA, w);
      expq.push_back(w & 32'h00FF_FFFF);
    end
    rd(OFS_LEVEL, r); check(r == 32, "R3 level full", r, 32);
    wr(OFS_TXDATA, 32'hDEAD_BEEF);
    rd(OFS_LEVEL, r); check(r == 32, "R4 write while full dropped", r, 32);
    start_tx();
    pushed = 0;
    while (pushed < 10) begin
      rd(OFS_LEVEL, r);
      check(r <= 32, "R3 level bound", r, 32);
      if (r < 32) begin
        w = 32'h5A00_0000 | (32'h0012_3456 + 32'(pushed) * 32'h0011_0101);
        wr(OFS_TXDATA, w);
        expq.push_back(w & 32'h00FF_FFFF);
        pushed++;
      end
    end
    while (!(expq.size() == 0 && zeros >= 1)) @(negedge clk);
    check(k_words == 42, "R4 only accepted words sent", k_words, 42);
    stop_and_clear(0);
    rd(OFS_LEVEL, r); check(r == 0, "R10 level after clear", r, 0);

    // clear discards queued words
    for (int i = 0; i < 5; i++) wr(OFS_TXDATA, 32'h00F0_F0F0 + 32'(i));
    rd(OFS_LEVEL, r); check(r == 5, "R3 level before clear", r, 5);
    wr(OFS_CLEAR, 32'h0);
    rd(OFS_LEVEL, r); check(r == 0, "R10 clear empties queue", r, 0);
    start_tx();
    while (zeros < 2) @(negedge clk);
    check(k_words == 0, "R10 cleared words never sent", k_words, 0);
    stop_and_clear(1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule